// File: doc/BRIEF.md
# Vectored Interrupt Controller with Nonmaskable Input

This block sits between a group of interrupt sources and a small processor core. It collects level-style pending flags from several maskable sources and a single nonmaskable line. It picks one winner and offers it to the core as a request, a vector number and the word address of that vector's slot in the handler pointer table. When the core signals entry, the block sends a one-cycle acknowledge back to the chosen source, which then drops its pending flag.

A global enable sits in the top bit (bit 7) of an 8-bit status register. Software can write the whole register, or use dedicated set and clear strobes on the enable alone. The enable clears itself when the core enters a handler. It is set again on the return strobe, so handlers never nest. The nonmaskable line is edge-detected and is served whatever the enable holds.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, no request is raised and no acknowledge is driven.
- R2: A status write stores all eight bits of the write data. The value reads back from the next cycle, and bit 7 is the global enable.
- R3: For the enable bit, the clear strobe overrides the set strobe, and the set strobe overrides a status write. Bits 6:0 follow the write regardless.
- R4: A maskable source raises the request only while the enable is 1 and no handler is active. A flag that is pending while the enable is 0 stays requested until the enable becomes 1.
- R5: Among pending maskable sources the lowest index wins. Source i carries vector FIRST_VEC+i (default 3+i).
- R6: The table address is 2×(vector−1). With defaults, source 7 gives vector 10 at 0x0012 and the nonmaskable input gives vector 2 at 0x0002.
- R7: Entry with the request high pulses the chosen source's acknowledge in the same cycle. From the next cycle the enable reads 0 and the request stays low until return. Entry takes precedence over the strobes and the write.
- R8: The return strobe during an active handler sets the enable from the next cycle and ends the handler. A return strobe with no handler active is ignored.
- R9: A rising edge on the nonmaskable input is latched and requested even with the enable at 0. It outranks every maskable source, with vector NMI_VEC (default 2), and entry pulses its own acknowledge.
- R10: A nonmaskable line held high is served once per rising edge.
- R11: Entry while the request is low produces no acknowledge and leaves the enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pend | input | NUM_SRC | Pending flags of maskable sources |
| src_ack | output | NUM_SRC | One-cycle acknowledge to the served source |
| nmi_req | input | 1 | Nonmaskable request line, edge-detected |
| nmi_ack | output | 1 | One-cycle acknowledge for the nonmaskable source |
| core_irq | output | 1 | Request to the core |
| core_vec | output | VEC_W | Vector number of the current winner |
| core_addr | output | ADDR_W | Word address of that vector's table slot |
| core_enter | input | 1 | Core accepts the request and enters the handler |
| core_reti | input | 1 | Core returns from the handler |
| sr_we | input | 1 | Status register write strobe |
| sr_wdata | input | 8 | Status register write data |
| sr_rdata | output | 8 | Status register contents |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |

## Verification
A corrupted enable bit appears on sr_rdata[7] in the very next cycle. It also either raises core_irq while a maskable flag is pending or holds it low when it should rise. A stuck handler-active flag shows as core_irq frozen low after a return strobe. A lost or doubled nonmaskable latch shows as a missing vector 2, or a second vector 2 one cycle after return. A priority fault shows at once as the wrong vector, address or acknowledge bit in the cycle the request is offered.

// File: rtl/irq_vector_pkg.sv
// Package: constants and helpers shared by the interrupt controller.
// Assumes an 8-bit status register whose top bit is the global enable.
package irq_vector_pkg;
    localparam int SR_W    = 8;
    localparam int GIE_BIT = 7;

    // Word address of a vector's table slot: two words per slot, vector 1 at 0.
    function automatic logic [31:0] vec_word_addr(input logic [31:0] v);
        return (v - 32'd1) << 1;
    endfunction
endpackage

// File: rtl/irq_status_reg.sv
// Module: status register holding the global interrupt enable.
// Assumes enter and leave are never high together (entry needs no handler
// active, leaving needs one). Enable precedence: enter, leave, clr, set, write.
module irq_status_reg
    import irq_vector_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SR_W-1:0] wdata,
    input  logic            set_gie,
    input  logic            clr_gie,
    input  logic            enter,
    input  logic            leave,
    output logic [SR_W-1:0] rdata
);
    logic            gie_q;
    logic [SR_W-2:0] low_q;

    // Low bits: plain storage updated by software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     low_q <= '0;
        else if (wr_en) low_q <= wdata[SR_W-2:0];
    end

    // Enable bit: hardware entry/return first, then strobes, then writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       gie_q <= 1'b0;
        else if (enter)   gie_q <= 1'b0;
        else if (leave)   gie_q <= 1'b1;
        else if (clr_gie) gie_q <= 1'b0;
        else if (set_gie) gie_q <= 1'b1;
        else if (wr_en)   gie_q <= wdata[GIE_BIT];
    end

    // Read path: enable in the top bit.
    always_comb rdata = {gie_q, low_q};
endmodule

// File: rtl/irq_nmi_latch.sv
// Module: rising-edge detector and pending latch for the nonmaskable line.
// Assumes the line is synchronous to clk. A new edge in the cycle the
// pending request is taken keeps the latch set.
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic taken,
    output logic pend
);
    logic line_q;
    logic rise;

    // Previous level of the line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= nmi_req;
    end

    // Edge strobe.
    always_comb rise = nmi_req & ~line_q;

    // Pending latch: set by an edge, cleared when the core takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= 1'b0;
        else if (rise)  pend <= 1'b1;
        else if (taken) pend <= 1'b0;
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Module: fixed-priority picker, lowest index wins.
// Assumes N >= 1. Purely combinational; outputs are zero when no request.
module irq_prio_pick #(
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx
);
    // Scan upward and keep the first set bit.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                found    = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: vectored interrupt controller top.
// Assumes the core pulses core_enter only while it sees core_irq high (other
// pulses are ignored) and pulses core_reti once per handler. Sources hold
// their pending flag until they see their acknowledge.
module irq_vector_ctrl
    import irq_vector_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int VEC_W     = 8,
    parameter int ADDR_W    = 16,
    parameter int NMI_VEC   = 2,
    parameter int FIRST_VEC = 3,
    localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pend,
    output logic [NUM_SRC-1:0] src_ack,
    input  logic               nmi_req,
    output logic               nmi_ack,
    output logic               core_irq,
    output logic [VEC_W-1:0]   core_vec,
    output logic [ADDR_W-1:0]  core_addr,
    input  logic               core_enter,
    input  logic               core_reti,
    input  logic               sr_we,
    input  logic [SR_W-1:0]    sr_wdata,
    output logic [SR_W-1:0]    sr_rdata,
    input  logic               gie_set,
    input  logic               gie_clr
);
    localparam logic [VEC_W-1:0] NMI_V   = VEC_W'(NMI_VEC);
    localparam logic [VEC_W-1:0] FIRST_V = VEC_W'(FIRST_VEC);

    logic               in_handler;
    logic               nmi_pend;
    logic               src_any;
    logic [NUM_SRC-1:0] src_grant;
    logic [IDX_W-1:0]   src_idx;
    logic               take;
    logic               leave;
    logic               gie;

    irq_status_reg u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sr_we),
        .wdata   (sr_wdata),
        .set_gie (gie_set),
        .clr_gie (gie_clr),
        .enter   (take),
        .leave   (leave),
        .rdata   (sr_rdata)
    );

    irq_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_req (nmi_req),
        .taken   (take & nmi_pend),
        .pend    (nmi_pend)
    );

    irq_prio_pick #(.N(NUM_SRC)) u_pick (
        .req   (src_pend),
        .any   (src_any),
        .grant (src_grant),
        .idx   (src_idx)
    );

    // Request, entry and return qualification.
    always_comb begin
        gie      = sr_rdata[GIE_BIT];
        core_irq = ~in_handler & (nmi_pend | (gie & src_any));
        take     = core_enter & core_irq;
        leave    = core_reti & in_handler;
    end

    // Handler-active flag: blocks all requests until return.
    always_ff @(posedge clk) begin
        if (!rst_n)     in_handler <= 1'b0;
        else if (take)  in_handler <= 1'b1;
        else if (leave) in_handler <= 1'b0;
    end

    // Vector number and table address of the current winner.
    always_comb begin
        core_vec  = nmi_pend ? NMI_V
                             : FIRST_V + VEC_W'(src_idx);
        core_addr = ADDR_W'(vec_word_addr(32'(core_vec)));
    end

    // Acknowledge pulses in the entry cycle, to exactly one party.
    always_comb begin
        nmi_ack = take & nmi_pend;
        src_ack = (take && !nmi_pend) ? src_grant : '0;
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Module: property checker for irq_vector_ctrl, attached by bind.
// Assumes only port-level signals; tracks its own view of handler activity.
module irq_vector_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 8,
    parameter int NMI_VEC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_pend,
    input logic [NUM_SRC-1:0] src_ack,
    input logic               nmi_ack,
    input logic               core_irq,
    input logic [VEC_W-1:0]   core_vec,
    input logic               core_enter,
    input logic               core_reti,
    input logic               gie
);
    logic chk_active;

    // Own model of handler activity from entry and return strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)                        chk_active <= 1'b0;
        else if (core_enter && core_irq)   chk_active <= 1'b1;
        else if (core_reti)                chk_active <= 1'b0;
    end

    AST_NO_REQ_IN_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        chk_active |-> !core_irq); // R4
    AST_ACK_TO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_ack) |-> ((src_ack & src_pend) == src_ack)); // R5
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nmi_ack, src_ack})); // R7
    AST_ENTRY_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_enter && core_irq) |=> !gie); // R7
    AST_RETURN_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_active && core_reti) |=> gie); // R8
    AST_MASKED_ONLY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (core_irq && !gie) |-> (core_vec == VEC_W'(NMI_VEC))); // R9
    AST_ACK_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ((|src_ack) || nmi_ack) |-> (core_enter && core_irq)); // R11
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .NMI_VEC (NMI_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_pend   (src_pend),
    .src_ack    (src_ack),
    .nmi_ack    (nmi_ack),
    .core_irq   (core_irq),
    .core_vec   (core_vec),
    .core_enter (core_enter),
    .core_reti  (core_reti),
    .gie        (sr_rdata[7])
);

// File: tb/irq_vector_ctrl_bench.sv
// Bench: directed corner cases, then seeded random traffic, all compared
// against a cycle model built from the requirements.
module irq_vector_ctrl_bench;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_pend = '0;
    logic [NS-1:0] src_ack;
    logic          nmi_req = 1'b0;
    logic          nmi_ack;
    logic          core_irq;
    logic [7:0]    core_vec;
    logic [15:0]   core_addr;
    logic          core_enter = 1'b0;
    logic          core_reti = 1'b0;
    logic          sr_we = 1'b0;
    logic [7:0]    sr_wdata = '0;
    logic [7:0]    sr_rdata;
    logic          gie_set = 1'b0;
    logic          gie_clr = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    // Model state
    logic          m_gie = 0, m_active = 0, m_nmi_q = 0, m_nmi_pend = 0;
    logic [6:0]    m_low = '0;
    logic [NS-1:0] pend_q = '0;
    logic          nmi_lvl = 1'b0;

    // Last observed outputs
    logic          obs_irq, obs_nmi_ack;
    logic [7:0]    obs_vec, obs_sr;
    logic [15:0]   obs_addr;
    logic [NS-1:0] obs_ack;

    always #4 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_ack(src_ack),
        .nmi_req(nmi_req), .nmi_ack(nmi_ack), .core_irq(core_irq),
        .core_vec(core_vec), .core_addr(core_addr), .core_enter(core_enter),
        .core_reti(core_reti), .sr_we(sr_we), .sr_wdata(sr_wdata),
        .sr_rdata(sr_rdata), .gie_set(gie_set), .gie_clr(gie_clr)
    );

    function automatic int lowest(input logic [NS-1:0] p);
        for (int i = 0; i < NS; i++) if (p[i]) return i;
        return 0;
    endfunction

    function automatic logic exp_irq(input logic [NS-1:0] p);
        return !m_active && (m_nmi_pend || (m_gie && (|p)));
    endfunction

    function automatic logic [7:0] exp_vec(input logic [NS-1:0] p);
        return m_nmi_pend ? 8'd2 : 8'(3 + lowest(p));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // One cycle: drive, compare at the falling edge, advance the model.
    task automatic step(input logic [NS-1:0] add, input logic ent, input logic ret,
                        input logic st, input logic cl, input logic we, input logic [7:0] wd);
        logic          irq_e, take, rise;
        logic [NS-1:0] ack_e;
        @(posedge clk);
        #1;
        pend_q     = pend_q | add;
        src_pend   = pend_q;
        nmi_req    = nmi_lvl;
        core_enter = ent; core_reti = ret;
        gie_set = st; gie_clr = cl; sr_we = we; sr_wdata = wd;
        @(negedge clk);
        obs_irq = core_irq; obs_vec = core_vec; obs_addr = core_addr;
        obs_ack = src_ack; obs_nmi_ack = nmi_ack; obs_sr = sr_rdata;
        irq_e = exp_irq(pend_q);
        take  = ent && irq_e;
        ack_e = '0;
        if (take && !m_nmi_pend) ack_e[lowest(pend_q)] = 1'b1;
        chk("R4 irq", 32'(core_irq), 32'(irq_e));
        if (irq_e) begin
            chk("R5 vec", 32'(core_vec), 32'(exp_vec(pend_q)));
            chk("R6 addr", 32'(core_addr), 32'((exp_vec(pend_q) - 8'd1) * 2));
        end
        chk("R7 src_ack", 32'(src_ack), 32'(ack_e));
        chk("R9 nmi_ack", 32'(nmi_ack), 32'(take && m_nmi_pend));
        chk("R2 status", 32'(sr_rdata), 32'({m_gie, m_low}));
        // advance model
        rise = nmi_lvl && !m_nmi_q;
        m_nmi_q = nmi_lvl;
        if (take && m_nmi_pend) m_nmi_pend = 1'b0;
        if (rise) m_nmi_pend = 1'b1;
        if (we) m_low = wd[6:0];
        if (take)                m_gie = 1'b0;
        else if (ret && m_active) m_gie = 1'b1;
        else if (cl)             m_gie = 1'b0;
        else if (st)             m_gie = 1'b1;
        else if (we)             m_gie = wd[7];
        if (take)          m_active = 1'b1;
        else if (ret)      m_active = 1'b0;
        pend_q = pend_q & ~ack_e;
    endtask

    task automatic idle();
        step('0, 0, 0, 0, 0, 0, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        idle();                                   // R1 reset state
        chk("R1 status", 32'(obs_sr), 32'h00);
        chk("R1 irq", 32'(obs_irq), 0);
        chk("R1 ack", 32'({obs_nmi_ack, obs_ack}), 0);

        step('0, 0, 0, 0, 0, 1, 8'h5A); idle();   // R2 write/readback
        chk("R2 readback", 32'(obs_sr), 32'h5A);

        step('0, 0, 0, 0, 1, 1, 8'h80); idle();   // R3 clr beats write
        chk("R3 clr_over_wr", 32'(obs_sr), 32'h00);
        step('0, 0, 0, 1, 0, 1, 8'h01); idle();   // R3 set beats write
        chk("R3 set_over_wr", 32'(obs_sr), 32'h81);
        step('0, 0, 0, 1, 1, 0, 8'h00); idle();   // R3 clr beats set
        chk("R3 clr_over_set", 32'(obs_sr), 32'h01);

        step(8'hA0, 0, 0, 0, 0, 0, 8'h00);        // R4 masked while gie=0
        chk("R4 masked", 32'(obs_irq), 0);
        step('0, 0, 0, 1, 0, 0, 8'h00); idle();   // R4 served after enable
        chk("R4 later", 32'(obs_irq), 1);
        chk("R5 lowest", 32'(obs_vec), 8);
        step('0, 1, 0, 0, 0, 0, 8'h00);           // R7 entry
        chk("R7 ack", 32'(obs_ack), 32'h20);
        idle();
        chk("R7 gie_cleared", 32'(obs_sr[7]), 0);
        chk("R7 irq_blocked", 32'(obs_irq), 0);
        step('0, 0, 1, 0, 0, 0, 8'h00); idle();   // R8 return
        chk("R8 gie_set", 32'(obs_sr[7]), 1);
        chk("R6 vec10", 32'(obs_vec), 10);
        chk("R6 addr12", 32'(obs_addr), 32'h12);
        step('0, 1, 0, 0, 0, 0, 8'h00);
        step('0, 0, 1, 0, 0, 0, 8'h00);

        step('0, 0, 0, 0, 1, 0, 8'h00);           // R8 stray return ignored
        step('0, 0, 1, 0, 0, 0, 8'h00); idle();
        chk("R8 stray_reti", 32'(obs_sr[7]), 0);

        step('0, 1, 0, 0, 0, 0, 8'h00);           // R11 entry without request
        chk("R11 no_ack", 32'({obs_nmi_ack, obs_ack}), 0);
        idle();
        chk("R11 gie_kept", 32'(obs_sr[7]), 0);

        nmi_lvl = 1'b1;                           // R9 edge with gie=0
        step(8'h01, 0, 0, 1, 0, 0, 8'h00); idle();
        chk("R9 irq", 32'(obs_irq), 1);
        chk("R9 vec", 32'(obs_vec), 2);
        chk("R6 nmi_addr", 32'(obs_addr), 32'h02);
        step('0, 1, 0, 0, 0, 0, 8'h00);
        chk("R9 ack", 32'(obs_nmi_ack), 1);
        step('0, 0, 1, 0, 0, 0, 8'h00); idle();   // R10 held line not re-served
        chk("R10 next_src", 32'(obs_vec), 3);
        step('0, 1, 0, 0, 0, 0, 8'h00);
        step('0, 0, 1, 0, 0, 0, 8'h00); idle();
        chk("R10 once", 32'(obs_irq), 0);
        nmi_lvl = 1'b0;

        for (int k = 0; k < 3000; k++) begin      // seeded random traffic
            logic [NS-1:0] add;
            add = ($urandom % 6 == 0) ? NS'($urandom) : '0;
            if ($urandom % 20 == 0) nmi_lvl = ~nmi_lvl;
            step(add, $urandom % 3 == 0, $urandom % 4 == 0, $urandom % 8 == 0,
                 $urandom % 10 == 0, $urandom % 16 == 0, 8'($urandom));
        end
        finish_run();
    end
endmodule